// File: doc/BRIEF.md
# Flash Controller Status and Interrupt Register Unit

This unit is the software-facing event and interrupt block of a serial flash controller. It sits behind a small 32-bit register bus with separate read and write strobes and a one-cycle read latency. Peripheral logic feeds it single-cycle event pulses (overrun, chip-select rise, instruction end) and live level signals (receive full, transmit ready, transmitter idle, chip-select active). The unit keeps the edge events as sticky flags that clear when software reads the status word, and it drives one level-sensitive interrupt line from the status word gated by an interrupt mask.

The mask cannot be written directly. Software sets mask bits through an enable address and clears them through a disable address, then reads the result back from a read-only mask address. A control address accepts self-clearing command strobes: controller enable, controller disable, software reset and last-transfer. A mode word is kept as plain read/write storage for the serial engine and is returned to zero by software reset.

A typical command sequence reads the status word once to discard stale events, launches the command, then waits on the interrupt until both instruction end and chip-select rise have been observed, accumulating them across reads where they arrive separately.

Top module: `qspi_status_irq_unit`

## Requirements
- R1: After reset the mask reads 0, the controller-enabled output is 0, no sticky flag is set, the interrupt is low and the status word shows only the live level inputs.
- R2: A pulse on an edge event sets its sticky status bit (overrun bit 3, chip-select rise bit 8, instruction end bit 10); the bit stays set until a status read (address 0x10), which returns it as 1 and clears it for later reads.
- R3: An event pulse in the same cycle as a status read is not lost: that read returns the pre-pulse value and the next read returns the bit as 1.
- R4: Level bits (receive full bit 0, transmit ready bit 1, transmitter idle bit 2, chip-select active bit 9) follow their inputs and are not cleared by a status read.
- R5: Writing a 1 to a bit at the enable address 0x14 sets that mask bit and writing a 1 at the disable address 0x18 clears it, leaving bits written 0 unchanged; the mask reads back at 0x1C and holds only the implemented status bits 0, 1, 2, 3, 8, 9, 10 and 24 (mask 0x0100070F).
- R6: Writes to the mask address 0x1C or the status address 0x10 change neither the mask nor the status word.
- R7: The interrupt output is high exactly when the status word AND the mask is nonzero.
- R8: A control write (address 0x00) with bit 0 enables the controller and with bit 1 disables it; with both set the result is disabled. The enabled state shows on the enabled output and as status bit 24 from the next cycle.
- R9: A control write with bit 24 produces a one-cycle last-transfer pulse in the cycle after the write; the control address always reads 0.
- R10: A control write with bit 7 clears all sticky flags, the mask, the mode word and the enabled state, overriding any enable in the same write.
- R11: The mode word at address 0x04 reads back the last value written; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_cs_rise | input | 1 | Chip-select rise event pulse |
| ev_instr_end | input | 1 | Instruction end event pulse |
| lv_rx_full | input | 1 | Live receive-data-full level |
| lv_tx_ready | input | 1 | Live transmit-data-empty level |
| lv_tx_idle | input | 1 | Live transmitter-idle level |
| lv_cs_active | input | 1 | Live chip-select status level |
| irq | output | 1 | Level interrupt request |
| ctl_enabled | output | 1 | Controller enabled state |
| cmd_last_xfer | output | 1 | One-cycle last-transfer command pulse |
| mode_word | output | 32 | Stored mode word |

## Verification
The status path is driven with level inputs alone, with isolated event pulses, and with a pulse landing on the same cycle as a status read; comparing first and second reads separates sticky clear-on-read behaviour from live level tracking and shows whether a colliding event survives. The mask is driven with all-ones enable writes, partial disable writes and direct writes to the read-only addresses, which tells apart set/clear semantics, the implemented-bit filter and ignored writes. Control writes with single bits, both enable and disable together, and reset combined with enable distinguish the strobe priorities.

// File: rtl/qspi_sir_pkg.sv
package qspi_sir_pkg;

    localparam int DATA_W = 32;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_IEN  = 8'h14;
    localparam logic [7:0] OFS_IDIS = 8'h18;
    localparam logic [7:0] OFS_IMSK = 8'h1C;

    // Status bit positions
    localparam int SB_RXFULL  = 0;
    localparam int SB_TXREADY = 1;
    localparam int SB_TXIDLE  = 2;
    localparam int SB_OVR     = 3;
    localparam int SB_CSRISE  = 8;
    localparam int SB_CSACT   = 9;
    localparam int SB_IEND    = 10;
    localparam int SB_ENABLED = 24;

    // Control strobe bit positions
    localparam int CB_ENABLE  = 0;
    localparam int CB_DISABLE = 1;
    localparam int CB_SWRST   = 7;
    localparam int CB_LAST    = 24;

    // Sticky edge events
    localparam int N_EVT = 3;
    localparam int EVT_POS [N_EVT] = '{SB_OVR, SB_CSRISE, SB_IEND};

    // Live level inputs
    localparam int N_LVL = 4;
    localparam int LVL_POS [N_LVL] = '{SB_RXFULL, SB_TXREADY, SB_TXIDLE, SB_CSACT};

    function automatic logic [DATA_W-1:0] impl_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_EVT; i++) m[EVT_POS[i]] = 1'b1;
        for (int i = 0; i < N_LVL; i++) m[LVL_POS[i]] = 1'b1;
        m[SB_ENABLED] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] STAT_IMPL = impl_bits();

    typedef struct packed {
        logic ctrl_wr;
        logic mode_wr;
        logic ien_wr;
        logic idis_wr;
        logic stat_rd;
    } bus_strb_t;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_MODE,
        RSEL_STAT,
        RSEL_MASK
    } rsel_e;

    typedef struct packed {
        logic enable;
        logic disable_;
        logic swrst;
        logic last;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic [DATA_W-1:0] w);
        ctrl_cmd_t c;
        c.enable   = w[CB_ENABLE];
        c.disable_ = w[CB_DISABLE];
        c.swrst    = w[CB_SWRST];
        c.last     = w[CB_LAST];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] build_status(
        input logic [N_EVT-1:0] sticky,
        input logic [N_LVL-1:0] lvl,
        input logic             en
    );
        logic [DATA_W-1:0] s;
        s = '0;
        for (int i = 0; i < N_EVT; i++) s[EVT_POS[i]] = sticky[i];
        for (int i = 0; i < N_LVL; i++) s[LVL_POS[i]] = lvl[i];
        s[SB_ENABLED] = en;
        return s;
    endfunction

endpackage

// File: rtl/sir_bus_decode.sv
module sir_bus_decode
    import qspi_sir_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_strb_t         strb,
    output rsel_e             rsel
);
    localparam int CMP_W = (ADDR_W < 8) ? ADDR_W : 8;

    logic [7:0] a8;

    always_comb begin
        a8 = '0;
        a8[CMP_W-1:0] = bus_addr[CMP_W-1:0];
    end

    logic hi_zero;
    generate
        if (ADDR_W > 8) begin : g_hi
            assign hi_zero = (bus_addr[ADDR_W-1:8] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        strb.ctrl_wr = bus_wr && hi_zero && (a8 == OFS_CTRL);
        strb.mode_wr = bus_wr && hi_zero && (a8 == OFS_MODE);
        strb.ien_wr  = bus_wr && hi_zero && (a8 == OFS_IEN);
        strb.idis_wr = bus_wr && hi_zero && (a8 == OFS_IDIS);
        strb.stat_rd = bus_rd && hi_zero && (a8 == OFS_STAT);
    end

    always_comb begin
        rsel = RSEL_NONE;
        if (hi_zero) begin
            unique case (a8)
                OFS_MODE: rsel = RSEL_MODE;
                OFS_STAT: rsel = RSEL_STAT;
                OFS_IMSK: rsel = RSEL_MASK;
                default:  rsel = RSEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sir_event_bank.sv
module sir_event_bank
    import qspi_sir_pkg::*;
#(
    parameter int NUM_EVT = N_EVT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_all,
    input  logic               rd_clear,
    input  logic [NUM_EVT-1:0] ev_in,
    output logic [NUM_EVT-1:0] sticky
);
    generate
        for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
            always_ff @(posedge clk) begin
                if (rst || clr_all) begin
                    sticky[i] <= 1'b0;
                end else begin
                    // A pulse coinciding with a read wins over the clear.
                    sticky[i] <= (sticky[i] && !rd_clear) || ev_in[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sir_mask_reg.sv
module sir_mask_reg
    import qspi_sir_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL = STAT_IMPL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);
    logic [DATA_W-1:0] sel;

    assign sel = wdata & IMPL;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            mask <= '0;
        end else if (set_wr) begin
            mask <= mask | sel;
        end else if (clr_wr) begin
            mask <= mask & ~sel;
        end
    end
endmodule

// File: rtl/sir_ctrl_regs.sv
module sir_ctrl_regs
    import qspi_sir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              swrst_now,
    output logic              enabled,
    output logic              last_pulse,
    output logic [DATA_W-1:0] mode_q
);
    ctrl_cmd_t cmd;

    assign cmd       = decode_ctrl(wdata);
    assign swrst_now = ctrl_wr && cmd.swrst;

    always_ff @(posedge clk) begin
        if (rst || swrst_now) begin
            enabled <= 1'b0;
        end else if (ctrl_wr) begin
            // enable applied first, then disable
            enabled <= (enabled || cmd.enable) && !cmd.disable_;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pulse <= 1'b0;
        end else begin
            last_pulse <= ctrl_wr && cmd.last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || swrst_now) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= wdata;
        end
    end
endmodule

// File: rtl/qspi_status_irq_unit.sv
module qspi_status_irq_unit
    import qspi_sir_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              ev_overrun,
    input  logic              ev_cs_rise,
    input  logic              ev_instr_end,
    input  logic              lv_rx_full,
    input  logic              lv_tx_ready,
    input  logic              lv_tx_idle,
    input  logic              lv_cs_active,
    output logic              irq,
    output logic              ctl_enabled,
    output logic              cmd_last_xfer,
    output logic [31:0]       mode_word
);
    bus_strb_t         strb;
    rsel_e             rsel;
    logic              swrst_now;
    logic [N_EVT-1:0]  ev_vec;
    logic [N_EVT-1:0]  sticky;
    logic [N_LVL-1:0]  lvl_vec;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_mux;

    assign ev_vec  = {ev_instr_end, ev_cs_rise, ev_overrun};
    assign lvl_vec = {lv_cs_active, lv_tx_idle, lv_tx_ready, lv_rx_full};

    sir_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .strb     (strb),
        .rsel     (rsel)
    );

    sir_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (strb.ctrl_wr),
        .mode_wr    (strb.mode_wr),
        .wdata      (bus_wdata),
        .swrst_now  (swrst_now),
        .enabled    (ctl_enabled),
        .last_pulse (cmd_last_xfer),
        .mode_q     (mode_word)
    );

    sir_event_bank #(.NUM_EVT(N_EVT)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (swrst_now),
        .rd_clear (strb.stat_rd),
        .ev_in    (ev_vec),
        .sticky   (sticky)
    );

    sir_mask_reg #(.IMPL(STAT_IMPL)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .clr_all (swrst_now),
        .set_wr  (strb.ien_wr),
        .clr_wr  (strb.idis_wr),
        .wdata   (bus_wdata),
        .mask    (mask_q)
    );

    assign stat_word = build_status(sticky, lvl_vec, ctl_enabled);
    assign irq       = |(stat_word & mask_q);

    always_comb begin
        unique case (rsel)
            RSEL_MODE: rd_mux = mode_word;
            RSEL_STAT: rd_mux = stat_word;
            RSEL_MASK: rd_mux = mask_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/qspi_status_irq_unit_chk.sv
module qspi_status_irq_unit_chk
    import qspi_sir_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              ev_overrun,
    input logic              ev_instr_end,
    input logic              irq,
    input logic              ctl_enabled,
    input logic              cmd_last_xfer,
    input logic [31:0]       mask_q,
    input logic [N_EVT-1:0]  sticky
);
    logic srst_req, stat_read, ctrl_w, ien_w;

    assign ctrl_w    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign ien_w     = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
    assign srst_req  = ctrl_w && bus_wdata[CB_SWRST];
    assign stat_read = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));

    // R2
    evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_overrun && !srst_req) |=> sticky[0]);

    // R3
    evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky[2] && !stat_read && !srst_req) |=> sticky[2]);

    // R3
    evt_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_instr_end && stat_read && !srst_req) |=> sticky[2]);

    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        ien_w |=> ((mask_q & $past(bus_wdata & STAT_IMPL)) == $past(bus_wdata & STAT_IMPL)));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    // R8
    disable_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_w && bus_wdata[CB_DISABLE]) |=> !ctl_enabled);

    // R9
    last_src_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_last_xfer |-> $past(ctrl_w && bus_wdata[CB_LAST]));

    // R10
    swrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        srst_req |=> (mask_q == '0 && !ctl_enabled && sticky == '0));
endmodule

bind qspi_status_irq_unit qspi_status_irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .ev_overrun    (ev_overrun),
    .ev_instr_end  (ev_instr_end),
    .irq           (irq),
    .ctl_enabled   (ctl_enabled),
    .cmd_last_xfer (cmd_last_xfer),
    .mask_q        (mask_q),
    .sticky        (sticky)
);

// File: tb/qspi_status_irq_unit_bench.sv
module qspi_status_irq_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        ev_overrun = 1'b0, ev_cs_rise = 1'b0, ev_instr_end = 1'b0;
    logic        lv_rx_full = 1'b0, lv_tx_ready = 1'b0, lv_tx_idle = 1'b0, lv_cs_active = 1'b0;
    logic        irq, ctl_enabled, cmd_last_xfer;
    logic [31:0] mode_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    qspi_status_irq_unit u_qspi_status_irq_unit (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .ev_overrun(ev_overrun), .ev_cs_rise(ev_cs_rise), .ev_instr_end(ev_instr_end),
        .lv_rx_full(lv_rx_full), .lv_tx_ready(lv_tx_ready), .lv_tx_idle(lv_tx_idle),
        .lv_cs_active(lv_cs_active), .irq(irq), .ctl_enabled(ctl_enabled),
        .cmd_last_xfer(cmd_last_xfer), .mode_word(mode_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data when the design returns it.
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("unexpected read data", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ev_overrun = 1'b1;
        if (which == 1) ev_cs_rise = 1'b1;
        if (which == 2) ev_instr_end = 1'b1;
        @(negedge clk);
        ev_overrun = 1'b0; ev_cs_rise = 1'b0; ev_instr_end = 1'b0;
    endtask

    task automatic read_with_iend(input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = 8'h10; ev_instr_end = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; ev_instr_end = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 enabled", {31'b0, ctl_enabled}, 32'h0);
        bus_read(8'h10, 32'h0, "R1 status");
        bus_read(8'h1C, 32'h0, "R1 mask");

        // R4 level bits live and not cleared
        lv_rx_full = 1'b1; lv_tx_idle = 1'b1; lv_cs_active = 1'b1;
        bus_read(8'h10, 32'h0000_0205, "R4 level read 1");
        bus_read(8'h10, 32'h0000_0205, "R4 level read 2");
        lv_rx_full = 1'b0; lv_tx_idle = 1'b0; lv_cs_active = 1'b0;
        lv_tx_ready = 1'b1;
        bus_read(8'h10, 32'h0000_0002, "R4 level follows");
        lv_tx_ready = 1'b0;

        // R2 sticky, clear on read
        pulse(0);
        pulse(1);
        repeat (2) @(negedge clk);
        bus_read(8'h10, 32'h0000_0108, "R2 sticky set");
        bus_read(8'h10, 32'h0000_0000, "R2 cleared by read");

        // R3 event colliding with read
        read_with_iend(32'h0000_0000, "R3 colliding read");
        bus_read(8'h10, 32'h0000_0400, "R3 event kept");
        bus_read(8'h10, 32'h0000_0000, "R3 then cleared");

        // R5 mask set/clear
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h1C, 32'h0100_070F, "R5 set all implemented");
        bus_write(8'h18, 32'h0000_0103);
        bus_read(8'h1C, 32'h0100_060C, "R5 partial clear");

        // R6 ignored writes
        bus_write(8'h1C, 32'h0000_0000);
        bus_read(8'h1C, 32'h0100_060C, "R6 mask write ignored");
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, 32'h0000_0000, "R6 status write ignored");

        // R7 interrupt
        #1;
        check("R7 irq low", {31'b0, irq}, 32'h0);
        lv_rx_full = 1'b1;
        #1;
        check("R7 unmasked level no irq", {31'b0, irq}, 32'h0);
        lv_rx_full = 1'b0;
        pulse(2);
        #1;
        check("R7 irq on masked event", {31'b0, irq}, 32'h1);
        bus_read(8'h10, 32'h0000_0400, "R7 status read");
        check("R7 irq cleared", {31'b0, irq}, 32'h0);

        // R8 enable / disable
        bus_write(8'h00, 32'h0000_0001);
        #1;
        check("R8 enabled", {31'b0, ctl_enabled}, 32'h1);
        check("R7 irq on enabled bit", {31'b0, irq}, 32'h1);
        bus_read(8'h10, 32'h0100_0000, "R8 status bit 24");
        bus_write(8'h00, 32'h0000_0003);
        #1;
        check("R8 both gives disabled", {31'b0, ctl_enabled}, 32'h0);

        // R9 last transfer pulse
        bus_write(8'h00, 32'h0100_0000);
        #1;
        check("R9 pulse high", {31'b0, cmd_last_xfer}, 32'h1);
        @(negedge clk); #1;
        check("R9 pulse one cycle", {31'b0, cmd_last_xfer}, 32'h0);
        bus_read(8'h00, 32'h0000_0000, "R9 control reads 0");

        // R11 mode word
        bus_write(8'h04, 32'hA5A5_1234);
        bus_read(8'h04, 32'hA5A5_1234, "R11 mode readback");
        bus_read(8'h40, 32'h0000_0000, "R11 unmapped reads 0");

        // R10 software reset
        bus_write(8'h00, 32'h0000_0001);
        pulse(0);
        bus_write(8'h00, 32'h0000_0081);
        #1;
        check("R10 enabled cleared", {31'b0, ctl_enabled}, 32'h0);
        check("R10 mode cleared", mode_word, 32'h0);
        bus_read(8'h1C, 32'h0000_0000, "R10 mask cleared");
        bus_read(8'h10, 32'h0000_0000, "R10 status cleared");

        repeat (2) @(negedge clk);
        check("queue drained", exp_q.size(), 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                check("watchdog expired", 32'h1, 32'h0);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule